// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block sits between a CAN receive engine and the host CPU and decides whether each completed frame is kept. When the engine reports a finished frame, its four identifier bytes and its format flag are placed in a background receive buffer. At the same time the identifier is compared, bit by bit, against programmable acceptance bytes. Per-bit mask bytes select which bits are compared and which are ignored. Extended-format frames are compared on all four bytes; standard-format frames use only the two leading bytes.

A frame that passes the comparison is swapped into the foreground buffer for the CPU, and a sticky receive-full flag is set. A frame that fails is left in the background buffer, and the next frame overwrites it. If a passing frame arrives while the CPU has not yet cleared receive-full, the frame is held in the background buffer and an overrun flag is raised. The acceptance and mask bytes are written through a small register port. Writes to them are honoured only in initialisation mode, so the filter cannot change while frames are being received. The two flags share a status register and are cleared by writing a one to them.

Top module: `can_id_filter`

## Requirements
- R1: After reset, every acceptance byte, mask byte and status bit reads 0, and the foreground and background identifiers with their format flags are 0.
- R2: Register addresses 0 to 3 hold acceptance bytes 0 to 3, and addresses 4 to 7 hold mask bytes 0 to 3. A write to any of these changes it only while `init_mode` is 1; at other times the write has no effect on the readback.
- R3: A mask bit of 1 makes the matching identifier bit don't-care. A mask bit of 0 requires the identifier bit to equal the acceptance bit. A frame passes only if every unmasked bit of every byte that applies matches.
- R4: For an extended frame (`frm_ext`=1), all four bytes take part in the comparison. Byte 0 is `frm_id[31:24]` and byte 3 is `frm_id[7:0]`.
- R5: For a standard frame (`frm_ext`=0), only bytes 0 and 1 (`frm_id[31:16]`) are compared, and bytes 2 and 3 have no effect on the result.
- R6: A frame that fails, presented with `init_mode`=0, appears in `bg_id`/`bg_ext` on the cycle after it is presented. `fg_id` is unchanged and `frm_drop` pulses for one cycle.
- R7: A frame that passes while receive-full is 0 swaps the buffers on the cycle after it is presented. The frame moves to `fg_id`, the old foreground moves to `bg_id`, receive-full (status bit 0, address 8) becomes 1, and `frm_accept` and `buf_swap` pulse for one cycle.
- R8: A frame that passes while receive-full is 1 is held in `bg_id` and leaves `fg_id` unchanged. Overrun (status bit 1) is set, `frm_accept` pulses and `buf_swap` stays 0.
- R9: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. Both flags otherwise hold their value.
- R10: A frame presented while `init_mode` is 1 is ignored: the buffers, the flags and the outcome pulses do not change.
- R11: `frm_accept` and `frm_drop` are never both 1, and `buf_swap` is 1 only together with `frm_accept`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_mode | input | 1 | Initialisation mode: acceptance/mask writes allowed, frames ignored |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (0-3 acceptance, 4-7 mask, 8 status) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| frm_valid | input | 1 | One-cycle strobe: a completed frame is present |
| frm_id | input | 32 | Identifier bytes 0..3 of the frame, byte 0 in the top bits |
| frm_ext | input | 1 | 1 for an extended-format identifier, 0 for standard |
| frm_accept | output | 1 | Pulse: the last frame passed the filter |
| frm_drop | output | 1 | Pulse: the last frame failed the filter |
| buf_swap | output | 1 | Pulse: the buffers were exchanged |
| fg_id | output | 32 | Foreground buffer identifier |
| fg_ext | output | 1 | Foreground buffer format flag |
| bg_id | output | 32 | Background buffer identifier |
| bg_ext | output | 1 | Background buffer format flag |
| rx_full | output | 1 | Receive-full flag |
| overrun | output | 1 | Overrun flag |

## Verification
Register readback is combinational, so it is sampled one time unit after the address settles, with no clock edge in between. A frame strobe is driven at a falling edge and captured at the next rising edge. Every result of that frame (the outcome pulses, both buffers and both flags) is due on that edge and checked at the following falling edge, before another edge can clear a pulse. Status clears and register writes follow the same rule: each is checked at the first falling edge after the rising edge that captured it.

// File: rtl/can_filt_pkg.sv
// Package: shared types and constants for the CAN identifier acceptance filter.
// Assumes the register map places acceptance bytes first, mask bytes next,
// then a single status register.
package can_filt_pkg;

    // Width of one identifier byte / register
    localparam int BYTE_W = 8;

    // Status register bit positions
    localparam int ST_FULL = 0;
    localparam int ST_OVR  = 1;

    // Address region classification
    typedef enum logic [1:0] {
        RG_ACC  = 2'd0,
        RG_MSK  = 2'd1,
        RG_STAT = 2'd2,
        RG_NONE = 2'd3
    } reg_region_e;

    // Classify an address against a map of nbytes acceptance + nbytes mask + status
    function automatic reg_region_e classify(input int unsigned addr, input int unsigned nbytes);
        if (addr < nbytes)             return RG_ACC;
        else if (addr < 2 * nbytes)    return RG_MSK;
        else if (addr == 2 * nbytes)   return RG_STAT;
        else                           return RG_NONE;
    endfunction

endpackage

// File: rtl/filt_cfg_regs.sv
// Module: acceptance and mask register bank.
// Holds NBYTES acceptance bytes and NBYTES mask bytes. Byte k is stored at
// bit slice [BYTE_W*(NBYTES-1-k) +: BYTE_W] so the flat vectors line up with
// the frame identifier (byte 0 in the top bits). Writes land only while
// init_mode is high. Assumes a single write port, one byte per cycle.
module filt_cfg_regs
    import can_filt_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int AW     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init_mode,
    input  logic                     wr_en,
    input  logic [AW-1:0]            addr,
    input  logic [BYTE_W-1:0]        wdata,
    output logic [NBYTES*BYTE_W-1:0] acc_flat,
    output logic [NBYTES*BYTE_W-1:0] msk_flat
);

    localparam int MSK_BASE = NBYTES;

    logic cfg_wr;
    assign cfg_wr = wr_en && init_mode;

    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        localparam int LSB = BYTE_W * (NBYTES - 1 - k);

        // Acceptance byte k: load on an init-mode write to its address
        always_ff @(posedge clk) begin
            if (!rst_n)
                acc_flat[LSB +: BYTE_W] <= '0;
            else if (cfg_wr && addr == AW'(k))
                acc_flat[LSB +: BYTE_W] <= wdata;
        end

        // Mask byte k: load on an init-mode write to its address
        always_ff @(posedge clk) begin
            if (!rst_n)
                msk_flat[LSB +: BYTE_W] <= '0;
            else if (cfg_wr && addr == AW'(MSK_BASE + k))
                msk_flat[LSB +: BYTE_W] <= wdata;
        end
    end

endmodule

// File: rtl/filt_match.sv
// Module: combinational identifier comparator.
// Each byte passes when every bit either is masked (mask 1) or equals the
// acceptance bit. Bytes at index NSTD and above count only for extended
// frames. Assumes identifier and registers share the same byte layout.
module filt_match
    import can_filt_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int NSTD   = 2
) (
    input  logic [NBYTES*BYTE_W-1:0] id,
    input  logic                     ext,
    input  logic [NBYTES*BYTE_W-1:0] acc_flat,
    input  logic [NBYTES*BYTE_W-1:0] msk_flat,
    output logic                     hit
);

    logic [NBYTES-1:0] byte_ok;
    logic [NBYTES-1:0] byte_used;

    for (genvar k = 0; k < NBYTES; k++) begin : g_cmp
        localparam int LSB = BYTE_W * (NBYTES - 1 - k);
        logic [BYTE_W-1:0] bit_ok;

        // Per-bit pass: masked or equal
        always_comb begin
            bit_ok     = ~(id[LSB +: BYTE_W] ^ acc_flat[LSB +: BYTE_W]) | msk_flat[LSB +: BYTE_W];
            byte_ok[k] = &bit_ok;
        end

        if (k < NSTD) begin : g_std
            assign byte_used[k] = 1'b1;
        end else begin : g_ext
            assign byte_used[k] = ext;
        end
    end

    // Frame passes when every byte in use passes
    always_comb begin
        hit = &(byte_ok | ~byte_used);
    end

endmodule

// File: rtl/filt_rx_bufs.sv
// Module: background/foreground receive buffers and status flags.
// Every frame taken outside init mode lands in the background buffer. A
// passing frame swaps the buffers when receive-full is clear; otherwise it
// is held in the background buffer and overrun is raised. Outcome pulses
// are registered and last one cycle. Assumes hit is valid with frm_valid.
module filt_rx_bufs
    import can_filt_pkg::*;
#(
    parameter int IDW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           init_mode,
    input  logic           frm_valid,
    input  logic [IDW-1:0] frm_id,
    input  logic           frm_ext,
    input  logic           hit,
    input  logic [1:0]     clr,
    output logic [IDW-1:0] fg_id,
    output logic           fg_ext,
    output logic [IDW-1:0] bg_id,
    output logic           bg_ext,
    output logic           rx_full,
    output logic           overrun,
    output logic           accept_p,
    output logic           drop_p,
    output logic           swap_p
);

    logic take;
    logic pass;
    logic do_swap;
    logic do_ovr;

    // Decode this cycle's frame outcome
    always_comb begin
        take    = frm_valid && !init_mode;
        pass    = take && hit;
        do_swap = pass && !rx_full;
        do_ovr  = pass && rx_full;
    end

    // Buffer contents: swap on acceptance, else overwrite background
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fg_id  <= '0;
            fg_ext <= 1'b0;
            bg_id  <= '0;
            bg_ext <= 1'b0;
        end else if (do_swap) begin
            fg_id  <= frm_id;
            fg_ext <= frm_ext;
            bg_id  <= fg_id;
            bg_ext <= fg_ext;
        end else if (take) begin
            bg_id  <= frm_id;
            bg_ext <= frm_ext;
        end
    end

    // One-cycle outcome pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            accept_p <= 1'b0;
            drop_p   <= 1'b0;
            swap_p   <= 1'b0;
        end else begin
            accept_p <= pass;
            drop_p   <= take && !hit;
            swap_p   <= do_swap;
        end
    end

    // Sticky flags: set has priority over a write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_full <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (do_swap)          rx_full <= 1'b1;
            else if (clr[ST_FULL]) rx_full <= 1'b0;
            if (do_ovr)           overrun <= 1'b1;
            else if (clr[ST_OVR]) overrun <= 1'b0;
        end
    end

endmodule

// File: rtl/can_id_filter.sv
// Module: CAN identifier acceptance filter (top).
// Joins the register bank, the comparator and the buffer controller, and
// provides combinational readback of acceptance, mask and status registers.
// Assumes frames arrive as single-cycle strobes with the identifier valid.
module can_id_filter
    import can_filt_pkg::*;
#(
    parameter int NBYTES = 4,
    parameter int NSTD   = 2,
    parameter int AW     = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init_mode,
    input  logic                     reg_wr,
    input  logic [AW-1:0]            reg_addr,
    input  logic [BYTE_W-1:0]        reg_wdata,
    output logic [BYTE_W-1:0]        reg_rdata,
    input  logic                     frm_valid,
    input  logic [NBYTES*BYTE_W-1:0] frm_id,
    input  logic                     frm_ext,
    output logic                     frm_accept,
    output logic                     frm_drop,
    output logic                     buf_swap,
    output logic [NBYTES*BYTE_W-1:0] fg_id,
    output logic                     fg_ext,
    output logic [NBYTES*BYTE_W-1:0] bg_id,
    output logic                     bg_ext,
    output logic                     rx_full,
    output logic                     overrun
);

    localparam int IDW       = NBYTES * BYTE_W;
    localparam int STAT_ADDR = 2 * NBYTES;

    logic [IDW-1:0] acc_flat;
    logic [IDW-1:0] msk_flat;
    logic           hit;
    logic [1:0]     stat_clr;
    reg_region_e    rd_rgn;

    filt_cfg_regs #(.NBYTES(NBYTES), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_mode (init_mode),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .acc_flat  (acc_flat),
        .msk_flat  (msk_flat)
    );

    filt_match #(.NBYTES(NBYTES), .NSTD(NSTD)) u_match (
        .id       (frm_id),
        .ext      (frm_ext),
        .acc_flat (acc_flat),
        .msk_flat (msk_flat),
        .hit      (hit)
    );

    // Status write-one-to-clear strobes
    always_comb begin
        stat_clr = '0;
        if (reg_wr && reg_addr == AW'(STAT_ADDR))
            stat_clr = reg_wdata[1:0];
    end

    filt_rx_bufs #(.IDW(IDW)) u_bufs (
        .clk       (clk),
        .rst_n     (rst_n),
        .init_mode (init_mode),
        .frm_valid (frm_valid),
        .frm_id    (frm_id),
        .frm_ext   (frm_ext),
        .hit       (hit),
        .clr       (stat_clr),
        .fg_id     (fg_id),
        .fg_ext    (fg_ext),
        .bg_id     (bg_id),
        .bg_ext    (bg_ext),
        .rx_full   (rx_full),
        .overrun   (overrun),
        .accept_p  (frm_accept),
        .drop_p    (frm_drop),
        .swap_p    (buf_swap)
    );

    // Readback multiplexer over acceptance, mask and status registers
    always_comb begin
        int unsigned a;
        a         = int'(reg_addr);
        rd_rgn    = classify(a, NBYTES);
        reg_rdata = '0;
        case (rd_rgn)
            RG_ACC:  reg_rdata = acc_flat[BYTE_W*(NBYTES-1-a) +: BYTE_W];
            RG_MSK:  reg_rdata = msk_flat[BYTE_W*(2*NBYTES-1-a) +: BYTE_W];
            RG_STAT: begin
                reg_rdata[ST_FULL] = rx_full;
                reg_rdata[ST_OVR]  = overrun;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/can_id_filter_chk.sv
// Module: assertion checker for can_id_filter, attached by bind.
// Observes ports and the comparator result; holds no design state.
module can_id_filter_chk #(
    parameter int NBYTES = 4,
    parameter int AW     = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   init_mode,
    input logic                   reg_wr,
    input logic [AW-1:0]          reg_addr,
    input logic [7:0]             reg_wdata,
    input logic                   frm_valid,
    input logic                   hit,
    input logic [2*NBYTES*8-1:0]  cfg,
    input logic [NBYTES*8-1:0]    fg_id,
    input logic                   rx_full,
    input logic                   overrun,
    input logic                   frm_accept,
    input logic                   frm_drop,
    input logic                   buf_swap
);

    localparam int STAT_ADDR = 2 * NBYTES;

    logic clr_full;
    assign clr_full = reg_wr && reg_addr == AW'(STAT_ADDR) && reg_wdata[0];

    // R2: filter configuration frozen outside init mode
    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_mode |=> $stable(cfg));

    // R6: failing frame drops and leaves foreground untouched
    p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !init_mode && !hit) |=> (frm_drop && $stable(fg_id)));

    // R7: passing frame with room swaps and sets receive-full
    p_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !init_mode && hit && !rx_full) |=> (buf_swap && rx_full));

    // R8: passing frame while full raises overrun without swap
    p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && !init_mode && hit && rx_full) |=> (overrun && !buf_swap && $stable(fg_id)));

    // R9: receive-full holds unless cleared by a write of one
    p_full_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && !clr_full) |=> rx_full);

    // R10: frames in init mode produce no outcome
    p_init_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && init_mode) |=> (!frm_accept && !frm_drop));

    // R11: outcomes exclusive, swap only with accept
    p_one_outcome_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frm_accept, frm_drop}) && (!buf_swap || frm_accept));

endmodule

bind can_id_filter can_id_filter_chk #(.NBYTES(NBYTES), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_mode  (init_mode),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .frm_valid  (frm_valid),
    .hit        (hit),
    .cfg        ({acc_flat, msk_flat}),
    .fg_id      (fg_id),
    .rx_full    (rx_full),
    .overrun    (overrun),
    .frm_accept (frm_accept),
    .frm_drop   (frm_drop),
    .buf_swap   (buf_swap)
);

// File: tb/can_id_filter_bench.sv
module can_id_filter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_mode = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        frm_valid = 1'b0;
    logic [31:0] frm_id = '0;
    logic        frm_ext = 1'b0;
    logic        frm_accept, frm_drop, buf_swap;
    logic [31:0] fg_id, bg_id;
    logic        fg_ext, bg_ext, rx_full, overrun;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    can_id_filter u_can_id_filter (
        .clk(clk), .rst_n(rst_n), .init_mode(init_mode),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .frm_valid(frm_valid), .frm_id(frm_id), .frm_ext(frm_ext),
        .frm_accept(frm_accept), .frm_drop(frm_drop), .buf_swap(buf_swap),
        .fg_id(fg_id), .fg_ext(fg_ext), .bg_id(bg_id), .bg_ext(bg_ext),
        .rx_full(rx_full), .overrun(overrun)
    );

    // {acc, msk, id, ext, expected pass}
    localparam logic [97:0] VEC [11] = '{
        {32'h12345678, 32'h00000000, 32'h12345678, 1'b1, 1'b1}, // R4 exact
        {32'h12345678, 32'h00000000, 32'h12345679, 1'b1, 1'b0}, // R4 byte 3 differs
        {32'h12345678, 32'h00000000, 32'h1234FFFF, 1'b0, 1'b1}, // R5 bytes 2,3 ignored
        {32'h12345678, 32'h00000000, 32'h13345678, 1'b0, 1'b0}, // R5 byte 0 differs
        {32'h12345678, 32'h00000000, 32'h12355678, 1'b0, 1'b0}, // R5 byte 1 differs
        {32'h00000000, 32'hFFFFFFFF, 32'hDEADBEEF, 1'b1, 1'b1}, // R3 all don't-care
        {32'hA5000000, 32'h0F000000, 32'hAA000000, 1'b1, 1'b1}, // R3 masked nibble
        {32'hA5000000, 32'h0F000000, 32'hB5000000, 1'b1, 1'b0}, // R3 unmasked nibble
        {32'h000000F0, 32'h0000000F, 32'h000000F3, 1'b1, 1'b1}, // R3/R4 last byte masked
        {32'h000000F0, 32'h0000000F, 32'h000000E3, 1'b1, 1'b0}, // R3/R4 last byte mismatch
        {32'h00FF0000, 32'h00000000, 32'h00FF1234, 1'b0, 1'b1}  // R5 standard pass
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic load_filter(input logic [31:0] acc, input logic [31:0] msk);
        init_mode = 1'b1;
        for (int k = 0; k < 4; k++) wr(4'(k), acc[8*(3-k) +: 8]);
        for (int k = 0; k < 4; k++) wr(4'(4 + k), msk[8*(3-k) +: 8]);
        init_mode = 1'b0;
    endtask

    // Present a frame at a falling edge; returns at the falling edge after capture
    task automatic send(input logic [31:0] id, input logic ext);
        @(negedge clk);
        frm_valid = 1'b1; frm_id = id; frm_ext = ext;
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    initial begin
        logic [7:0] d;
        logic [31:0] fg_prev, bg_prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 9; a++) begin
            rd(4'(a), d);
            chk("R1 register", 32'(d), 32'h0);
        end
        chk("R1 fg_id", fg_id, 32'h0);
        chk("R1 bg_id", bg_id, 32'h0);
        chk("R1 ext flags", {30'b0, fg_ext, bg_ext}, 32'h0);

        // Vector table: R3, R4, R5, R6, R7, R11
        for (int v = 0; v < 11; v++) begin
            logic [31:0] acc, msk, id;
            logic ext, exp;
            {acc, msk, id, ext, exp} = VEC[v];
            load_filter(acc, msk);
            wr(4'd8, 8'h03);
            fg_prev = fg_id;
            send(id, ext);
            chk("R3/R4/R5 accept", {31'b0, frm_accept}, {31'b0, exp});
            chk("R11 drop exclusive", {31'b0, frm_drop}, {31'b0, !exp});
            chk("R7 swap", {31'b0, buf_swap}, {31'b0, exp});
            if (exp) begin
                chk("R7 fg_id", fg_id, id);
                chk("R7 bg_id old fg", bg_id, fg_prev);
                chk("R7 rx_full", {31'b0, rx_full}, 32'h1);
            end else begin
                chk("R6 bg_id", bg_id, id);
                chk("R6 bg_ext", {31'b0, bg_ext}, {31'b0, ext});
                chk("R6 fg unchanged", fg_id, fg_prev);
            end
        end

        // R2: writes outside init mode ignored
        load_filter(32'h11223344, 32'h55667788);
        wr(4'd0, 8'hEE);
        wr(4'd5, 8'hEE);
        rd(4'd0, d); chk("R2 acc0 unchanged", 32'(d), 32'h11);
        rd(4'd5, d); chk("R2 msk1 unchanged", 32'(d), 32'h66);
        rd(4'd3, d); chk("R2 acc3 readback", 32'(d), 32'h44);
        rd(4'd7, d); chk("R2 msk3 readback", 32'(d), 32'h88);

        // R8: accept while full holds frame in background, sets overrun
        load_filter(32'h0, 32'hFFFFFFFF);
        wr(4'd8, 8'h03);
        send(32'hAAAA0001, 1'b1);
        chk("R8 first swap", {31'b0, rx_full}, 32'h1);
        send(32'hBBBB0002, 1'b0);
        chk("R8 accept pulse", {31'b0, frm_accept}, 32'h1);
        chk("R8 no swap", {31'b0, buf_swap}, 32'h0);
        chk("R8 fg kept", fg_id, 32'hAAAA0001);
        chk("R8 bg holds new", bg_id, 32'hBBBB0002);
        chk("R8 overrun", {31'b0, overrun}, 32'h1);

        // R9: write-one-to-clear status
        wr(4'd8, 8'h00);
        rd(4'd8, d); chk("R9 write zero keeps", 32'(d), 32'h3);
        wr(4'd8, 8'h01);
        rd(4'd8, d); chk("R9 clear full only", 32'(d), 32'h2);
        wr(4'd8, 8'h02);
        rd(4'd8, d); chk("R9 clear overrun", 32'(d), 32'h0);

        // R10: frames in init mode ignored
        fg_prev = fg_id; bg_prev = bg_id;
        init_mode = 1'b1;
        send(32'h0BADF00D, 1'b1);
        chk("R10 no accept", {31'b0, frm_accept}, 32'h0);
        chk("R10 no drop", {31'b0, frm_drop}, 32'h0);
        chk("R10 bg unchanged", bg_id, bg_prev);
        chk("R10 fg unchanged", fg_id, fg_prev);
        chk("R10 flags unchanged", {30'b0, overrun, rx_full}, 32'h0);
        init_mode = 1'b0;

        @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule